// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block takes 53-byte ATM cells from a writer, stores them in a small cell FIFO, and hands them out one byte at a time to a line mapper that asks for bytes. A cell goes out only once all 53 of its bytes are held in the FIFO. When a cell boundary arrives and no complete cell is waiting, the block sends a rate-decoupling cell. This cell is either idle or unassigned. Its payload is filled with a programmable byte.

On the way out, the block can replace the fifth header byte with a CRC-8 header check. A programmable coset value is XORed into the check. The 48 payload bytes can be scrambled with a self-synchronising x^43+1 scrambler, while the header always passes through unscrambled. The FIFO capacity can be set to two, three or four cells. A flag tells the writer when room for two more cells is free. A one-shot request corrupts the header check of the next cell. A saturating counter records how many clean user cells were sent.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: `cfg_depth_sel` sets the FIFO capacity: 0 gives 2 cells, 1 gives 3 cells, and 2 or 3 gives 4 cells (53 bytes per cell). A byte written while the FIFO already holds capacity bytes is dropped.
- R2: `fifo_room2` is high exactly when the free space (capacity minus bytes held) is at least 106 bytes.
- R3: The header check is a CRC-8 with polynomial x^8+x^2+x+1. It starts from zero and runs over header bytes 1 to 4, most significant bit first, and the result is XORed with `cfg_coset`. With `cfg_hec_en`=1 this value replaces byte 5 of a user cell. With `cfg_hec_en`=0 the user's byte 5 passes unchanged. Fill cells always carry the computed value.
- R4: With `cfg_scr_en`=1, each payload byte (bytes 6 to 53) is scrambled most significant bit first as out = in XOR (output bit sent 43 bits earlier). The scrambler history is zero after reset and advances only on payload bytes sent while scrambling is enabled. Header bytes are never scrambled.
- R5: At a cell boundary with no complete cell stored, a fill cell is sent. Its header is 00 00 00 01 when `cfg_fill_unassigned`=0 and 00 00 00 00 when it is 1. With coset 0x55 this gives a check byte of 0x52 or 0x55 respectively.
- R6: Every payload byte of a fill cell, before scrambling, equals `cfg_fill_byte`.
- R7: A one-cycle `err_inject` pulse arms a flag. The check byte (byte 5) of the next cell sent has bit 0 inverted, and only that one cell is affected.
- R8: `tx_cell_count` rises by one when the last byte of a user cell without injected error is sent. It holds at its all-ones maximum, and fill cells and corrupted cells do not change it.
- R9: A partly written cell is never started. Fill cells are sent until its 53rd byte has been written.
- R10: When `line_req` is high at a clock edge, `line_vld` is high in the following cycle with the next byte on `line_data`, and `line_soc` marks the first byte of each cell. `line_vld` is low in any cycle that follows a clock edge where `line_req` was low.
- R11: After synchronous reset the FIFO is empty, `fifo_room2` is high, `line_vld` and `line_soc` are low, and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one cell byte into the FIFO |
| wr_data | input | 8 | Cell byte to write |
| fifo_room2 | output | 1 | Room for at least two more cells |
| line_req | input | 1 | Line side requests one byte |
| line_vld | output | 1 | Byte on line_data is valid |
| line_soc | output | 1 | Valid byte is the first byte of a cell |
| line_data | output | 8 | Outgoing cell byte |
| cfg_depth_sel | input | 2 | FIFO capacity select |
| cfg_hec_en | input | 1 | Insert the header check into user cells |
| cfg_coset | input | 8 | Value XORed into the header check |
| cfg_scr_en | input | 1 | Scramble payload bytes |
| cfg_fill_unassigned | input | 1 | Fill cells are unassigned rather than idle |
| cfg_fill_byte | input | 8 | Payload byte of fill cells |
| err_inject | input | 1 | Arm a single-bit error in the next check byte |
| tx_cell_count | output | CNT_W | Saturating count of clean user cells sent |

## Verification
A wrong FIFO byte count or complete-cell count shows up at the next cell boundary. The output then carries a fill cell where a user cell was due, or a stale cell appears, and the room flag moves at the wrong write. A wrong header check state corrupts byte 5 of the cell being sent. Because the scrambler feeds back its own output, a wrong history spoils each scrambled payload byte in the following 43-bit window, and this persists across cells. Whole-cell comparisons against a bench model therefore expose such faults within one cell.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;

    localparam int CELL_BYTES = 53;
    localparam int HEC_IDX    = 4;
    localparam int SCR_LEN    = 43;
    localparam logic [7:0] HEC_POLY = 8'h07;

    typedef logic [SCR_LEN-1:0] scr_state_t;

    typedef struct packed {
        scr_state_t st;
        logic [7:0] q;
    } scr_out_t;

    typedef enum logic [1:0] {
        SEG_HDR,
        SEG_HEC,
        SEG_PAY
    } seg_e;

    typedef struct packed {
        logic       vld;
        logic       soc;
        logic [7:0] data;
    } line_beat_t;

    // One byte of CRC-8, most significant bit first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ HEC_POLY) : (r << 1);
        end
        return r;
    endfunction

    // Self-synchronising scrambler over one byte, MSB first.
    function automatic scr_out_t scr_byte(input scr_state_t s, input logic [7:0] d);
        scr_out_t o;
        logic     b;
        o.st = s;
        o.q  = '0;
        for (int i = 7; i >= 0; i--) begin
            b      = d[i] ^ o.st[SCR_LEN-1];
            o.q[i] = b;
            o.st   = {o.st[SCR_LEN-2:0], b};
        end
        return o;
    endfunction

    function automatic int depth_cells(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd1:    return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/atm_tx_cell_fifo.sv
module atm_tx_cell_fifo
    import atm_tx_pkg::*;
#(
    parameter int MAX_CELLS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_depth_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_take,
    input  logic       cell_pop,
    output logic [7:0] rd_data,
    output logic       cells_ready,
    output logic       room2
);
    localparam int TOTAL = MAX_CELLS * CELL_BYTES;
    localparam int PW    = $clog2(TOTAL);
    localparam int OW    = $clog2(TOTAL + 1);
    localparam int CW    = $clog2(MAX_CELLS + 1);
    localparam int BW    = $clog2(CELL_BYTES);
    localparam logic [PW-1:0] PTR_LAST  = PW'(TOTAL - 1);
    localparam logic [BW-1:0] BYTE_LAST = BW'(CELL_BYTES - 1);
    localparam logic [OW-1:0] TWO_CELLS = OW'(2 * CELL_BYTES);

    logic [7:0]    mem [TOTAL];
    logic [PW-1:0] wp_q, rp_q;
    logic [OW-1:0] occ_q, cap, free_b;
    logic [BW-1:0] widx_q;
    logic [CW-1:0] done_q;
    logic          wr_ok, cell_end;

    always_comb begin
        int n;
        n = depth_cells(cfg_depth_sel);
        if (n > MAX_CELLS) n = MAX_CELLS;
        cap = OW'(n * CELL_BYTES);
    end

    assign wr_ok       = wr_en && (occ_q < cap);
    assign cell_end    = wr_ok && (widx_q == BYTE_LAST);
    assign free_b      = (occ_q >= cap) ? '0 : (cap - occ_q);
    assign room2       = free_b >= TWO_CELLS;
    assign rd_data     = mem[rp_q];
    assign cells_ready = done_q != '0;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q   <= '0;
            rp_q   <= '0;
            occ_q  <= '0;
            widx_q <= '0;
            done_q <= '0;
        end else begin
            if (wr_ok) begin
                wp_q   <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
                widx_q <= (widx_q == BYTE_LAST) ? '0 : widx_q + 1'b1;
            end
            if (rd_take) rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
            occ_q  <= occ_q + OW'(wr_ok) - OW'(rd_take);
            done_q <= done_q + CW'(cell_end) - CW'(cell_pop);
        end
    end

    // R9: a cell is only started when a complete one is stored
    a_r9_pop_needs_cell: assert property (@(posedge clk) disable iff (rst)
        cell_pop |-> done_q != '0);

    // R1: a write into a full FIFO never raises the byte count
    a_r1_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        (wr_en && occ_q >= cap) |=> occ_q <= $past(occ_q));

endmodule

// File: rtl/atm_tx_scrambler.sv
module atm_tx_scrambler
    import atm_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    scr_state_t st_q;
    scr_out_t   res;

    assign res  = scr_byte(st_q, din);
    assign dout = res.q;

    always_ff @(posedge clk) begin
        if (rst)          st_q <= '0;
        else if (advance) st_q <= res.st;
    end

    // R4: history only moves on scrambled payload bytes
    a_r4_scr_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(st_q));

endmodule

// File: rtl/atm_tx_cell_seq.sv
module atm_tx_cell_seq
    import atm_tx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_req,
    input  logic             cells_ready,
    input  logic [7:0]       fifo_data,
    input  logic             cfg_hec_en,
    input  logic [7:0]       cfg_coset,
    input  logic             cfg_scr_en,
    input  logic             cfg_fill_unassigned,
    input  logic [7:0]       cfg_fill_byte,
    input  logic             err_inject,
    input  logic [7:0]       scr_dout,
    output logic             rd_take,
    output logic             cell_pop,
    output logic             scr_adv,
    output logic [7:0]       scr_din,
    output line_beat_t       beat,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [5:0] LAST_IDX = 6'(CELL_BYTES - 1);
    localparam logic [5:0] HEC_POS  = 6'(HEC_IDX);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [5:0]       idx_q;
    logic             user_q, bad_q, armed_q;
    logic [7:0]       crc_q, crc_nxt, raw, fill_hdr, out_b, hec_gen;
    logic [CNT_W-1:0] cnt_q;
    line_beat_t       beat_q;
    seg_e             seg;
    logic             first, last, user_now;

    assign first    = idx_q == '0;
    assign last     = idx_q == LAST_IDX;
    assign user_now = first ? cells_ready : user_q;

    always_comb begin
        if (idx_q < HEC_POS)       seg = SEG_HDR;
        else if (idx_q == HEC_POS) seg = SEG_HEC;
        else                       seg = SEG_PAY;
    end

    assign fill_hdr = (idx_q == 6'd3 && !cfg_fill_unassigned) ? 8'h01 : 8'h00;
    assign raw      = user_now ? fifo_data : ((seg == SEG_PAY) ? cfg_fill_byte : fill_hdr);
    assign crc_nxt  = crc8_step(first ? 8'h00 : crc_q, raw);
    assign hec_gen  = crc_q ^ cfg_coset;

    always_comb begin
        case (seg)
            SEG_HDR: out_b = raw;
            SEG_HEC: out_b = ((user_now && !cfg_hec_en) ? raw : hec_gen) ^ {7'h00, armed_q};
            default: out_b = cfg_scr_en ? scr_dout : raw;
        endcase
    end

    assign scr_din  = raw;
    assign scr_adv  = line_req && (seg == SEG_PAY) && cfg_scr_en;
    assign rd_take  = line_req && user_now;
    assign cell_pop = line_req && first && cells_ready;
    assign beat     = beat_q;
    assign cnt      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            user_q  <= 1'b0;
            bad_q   <= 1'b0;
            armed_q <= 1'b0;
            crc_q   <= '0;
            cnt_q   <= '0;
            beat_q  <= '0;
        end else begin
            beat_q.vld <= line_req;
            beat_q.soc <= line_req && first;
            armed_q    <= (armed_q && !(line_req && seg == SEG_HEC)) || err_inject;
            if (line_req) begin
                beat_q.data <= out_b;
                idx_q       <= last ? '0 : idx_q + 1'b1;
                if (first) user_q <= cells_ready;
                if (seg == SEG_HDR) crc_q <= crc_nxt;
                if (seg == SEG_HEC) bad_q <= armed_q;
                if (last && user_q && !bad_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8: the counter never moves by more than one step upward
    a_r8_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

    // R8: the counter only moves after the last byte of a cell
    a_r8_cnt_at_end: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> ($past(line_req) && $past(idx_q) == LAST_IDX));

    // R7: the armed error is consumed by the check byte of one cell
    a_r7_arm_clears: assert property (@(posedge clk) disable iff (rst)
        (line_req && seg == SEG_HEC && !err_inject) |=> !armed_q);

endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
    import atm_tx_pkg::*;
#(
    parameter int MAX_CELLS = 4,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             fifo_room2,
    input  logic             line_req,
    output logic             line_vld,
    output logic             line_soc,
    output logic [7:0]       line_data,
    input  logic [1:0]       cfg_depth_sel,
    input  logic             cfg_hec_en,
    input  logic [7:0]       cfg_coset,
    input  logic             cfg_scr_en,
    input  logic             cfg_fill_unassigned,
    input  logic [7:0]       cfg_fill_byte,
    input  logic             err_inject,
    output logic [CNT_W-1:0] tx_cell_count
);
    logic       rd_take, cell_pop, cells_ready, scr_adv;
    logic [7:0] rd_data, scr_din, scr_dout;
    line_beat_t beat;

    atm_tx_cell_fifo #(.MAX_CELLS(MAX_CELLS)) u_fifo (
        .clk(clk), .rst(rst), .cfg_depth_sel(cfg_depth_sel),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_take(rd_take), .cell_pop(cell_pop),
        .rd_data(rd_data), .cells_ready(cells_ready), .room2(fifo_room2)
    );

    atm_tx_scrambler u_scr (
        .clk(clk), .rst(rst), .advance(scr_adv), .din(scr_din), .dout(scr_dout)
    );

    atm_tx_cell_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .line_req(line_req),
        .cells_ready(cells_ready), .fifo_data(rd_data),
        .cfg_hec_en(cfg_hec_en), .cfg_coset(cfg_coset), .cfg_scr_en(cfg_scr_en),
        .cfg_fill_unassigned(cfg_fill_unassigned), .cfg_fill_byte(cfg_fill_byte),
        .err_inject(err_inject), .scr_dout(scr_dout),
        .rd_take(rd_take), .cell_pop(cell_pop), .scr_adv(scr_adv), .scr_din(scr_din),
        .beat(beat), .cnt(tx_cell_count)
    );

    assign line_vld  = beat.vld;
    assign line_soc  = beat.soc;
    assign line_data = beat.data;

    // R10: a start-of-cell marker only comes with a valid byte
    a_r10_soc_has_vld: assert property (@(posedge clk) disable iff (rst)
        line_soc |-> line_vld);

endmodule

// File: tb/atm_tx_cell_proc_tb.sv
module atm_tx_cell_proc_tb_top;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          fifo_room2;
    logic          line_req = 1'b0;
    logic          line_vld, line_soc;
    logic [7:0]    line_data;
    logic [1:0]    cfg_depth_sel = 2'd2;
    logic          cfg_hec_en = 1'b1;
    logic [7:0]    cfg_coset = 8'h55;
    logic          cfg_scr_en = 1'b0;
    logic          cfg_fill_unassigned = 1'b0;
    logic [7:0]    cfg_fill_byte = 8'h6A;
    logic          err_inject = 1'b0;
    logic [CW-1:0] tx_cell_count;

    int         n_tests = 0;
    int         n_fail  = 0;
    int         exp_cnt = 0;
    logic [42:0] m_scr  = '0;
    logic [7:0]  last_got [53];

    // flags[7:0] (bit0 check insert, bit1 scramble), coset, seed, byte5, header
    localparam logic [63:0] VEC [6] = '{
        64'h01_55_10_00_12345678,
        64'h01_00_20_00_0A0B0C0D,
        64'h00_55_30_A5_01020304,
        64'h03_55_40_00_FFFFFFFF,
        64'h03_55_50_00_00000010,
        64'h02_00_60_3C_DEADBEEF
    };

    atm_tx_cell_proc #(.MAX_CELLS(4), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_room2(fifo_room2), .line_req(line_req), .line_vld(line_vld),
        .line_soc(line_soc), .line_data(line_data), .cfg_depth_sel(cfg_depth_sel),
        .cfg_hec_en(cfg_hec_en), .cfg_coset(cfg_coset), .cfg_scr_en(cfg_scr_en),
        .cfg_fill_unassigned(cfg_fill_unassigned), .cfg_fill_byte(cfg_fill_byte),
        .err_inject(err_inject), .tx_cell_count(tx_cell_count)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_hec(input logic [31:0] h);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            fb = c[7] ^ h[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic scr_model(input logic [7:0] d, output logic [7:0] q);
        for (int i = 7; i >= 0; i--) begin
            q[i]  = d[i] ^ m_scr[42];
            m_scr = {m_scr[41:0], q[i]};
        end
    endtask

    function automatic logic [7:0] cell_byte(input logic [31:0] h, input logic [7:0] b5,
                                             input logic [7:0] seed, input int k);
        if (k < 4)  return h[31-8*k -: 8];
        if (k == 4) return b5;
        return seed + 8'(7 * (k - 5));
    endfunction

    task automatic write_cell(input logic [31:0] h, input logic [7:0] b5,
                              input logic [7:0] seed, input int from, input int upto);
        for (int k = from; k <= upto; k++) begin
            wr_en   = 1'b1;
            wr_data = cell_byte(h, b5, seed, k);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic expect_cell(input bit user, input logic [31:0] h, input logic [7:0] b5,
                               input logic [7:0] seed, input bit inj, input string req);
        logic [7:0]  e [53];
        logic [31:0] hh;
        logic [7:0]  p, q;
        bit          fr_ok;
        int          bad;
        hh = user ? h : {31'h0, !cfg_fill_unassigned};
        for (int k = 0; k < 4; k++) e[k] = hh[31-8*k -: 8];
        e[4] = ((user && !cfg_hec_en) ? b5 : (ref_hec(hh) ^ cfg_coset)) ^ {7'h0, inj};
        for (int k = 5; k < 53; k++) begin
            p = user ? cell_byte(h, b5, seed, k) : cfg_fill_byte;
            if (cfg_scr_en) begin
                scr_model(p, q);
                p = q;
            end
            e[k] = p;
        end
        fr_ok    = 1'b1;
        line_req = 1'b1;
        for (int k = 0; k < 53; k++) begin
            @(negedge clk);
            last_got[k] = line_data;
            if (!line_vld || (line_soc != (k == 0))) fr_ok = 1'b0;
        end
        line_req = 1'b0;
        bad = -1;
        for (int k = 0; k < 53; k++) if (bad < 0 && last_got[k] !== e[k]) bad = k;
        chk(bad < 0, req, $sformatf("cell byte %0d", bad),
            (bad < 0) ? 32'h0 : {24'h0, last_got[bad]}, (bad < 0) ? 32'h0 : {24'h0, e[bad]});
        chk(fr_ok, "R10", "valid/start flags over a cell", {31'h0, fr_ok}, 32'h1);
        if (user && !inj && exp_cnt < 7) exp_cnt++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(line_vld == 1'b0, "R11", "line_vld after reset", {31'h0, line_vld}, 32'h0);
        chk(fifo_room2 == 1'b1, "R11", "room flag after reset", {31'h0, fifo_room2}, 32'h1);
        chk(tx_cell_count == '0, "R11", "counter after reset", 32'(tx_cell_count), 32'h0);

        // R5 R6 idle fill cell, check byte 0x52
        expect_cell(1'b0, '0, '0, '0, 1'b0, "R5");
        chk(last_got[4] == 8'h52, "R3", "idle check byte", {24'h0, last_got[4]}, 32'h52);
        cfg_fill_unassigned = 1'b1;
        cfg_fill_byte = 8'hC3;
        expect_cell(1'b0, '0, '0, '0, 1'b0, "R6");
        chk(last_got[4] == 8'h55, "R5", "unassigned check byte", {24'h0, last_got[4]}, 32'h55);
        cfg_fill_unassigned = 1'b0;
        @(negedge clk);
        chk(line_vld == 1'b0, "R10", "no valid without request", {31'h0, line_vld}, 32'h0);

        // table of user cells: R3 check insertion, R4 scrambling
        for (int v = 0; v < 6; v++) begin
            cfg_hec_en = VEC[v][56];
            cfg_scr_en = VEC[v][57];
            cfg_coset  = VEC[v][55:48];
            write_cell(VEC[v][31:0], VEC[v][39:32], VEC[v][47:40], 0, 52);
            expect_cell(1'b1, VEC[v][31:0], VEC[v][39:32], VEC[v][47:40], 1'b0,
                        VEC[v][57] ? "R4" : "R3");
        end
        // R4 scrambled fill cell continues the same history
        expect_cell(1'b0, '0, '0, '0, 1'b0, "R4");
        cfg_scr_en = 1'b0;
        cfg_hec_en = 1'b1;
        cfg_coset  = 8'h55;
        chk(32'(tx_cell_count) == exp_cnt, "R8", "count after table", 32'(tx_cell_count), exp_cnt);

        // R7 single error injection, affects one cell only, not counted
        err_inject = 1'b1;
        @(negedge clk);
        err_inject = 1'b0;
        write_cell(32'h11223344, 8'h00, 8'h70, 0, 52);
        expect_cell(1'b1, 32'h11223344, 8'h00, 8'h70, 1'b1, "R7");
        chk(32'(tx_cell_count) == exp_cnt, "R7", "count after corrupted cell", 32'(tx_cell_count), exp_cnt);
        write_cell(32'h55667788, 8'h00, 8'h80, 0, 52);
        expect_cell(1'b1, 32'h55667788, 8'h00, 8'h80, 1'b0, "R7");

        // R9 partial cell is not started
        write_cell(32'hCAFE0001, 8'h00, 8'h90, 0, 51);
        expect_cell(1'b0, '0, '0, '0, 1'b0, "R9");
        write_cell(32'hCAFE0001, 8'h00, 8'h90, 52, 52);
        expect_cell(1'b1, 32'hCAFE0001, 8'h00, 8'h90, 1'b0, "R9");
        chk(32'(tx_cell_count) == 7, "R8", "saturated count", 32'(tx_cell_count), 32'd7);

        // R1 R2 two-cell depth, third cell dropped
        cfg_depth_sel = 2'd0;
        @(negedge clk);
        chk(fifo_room2 == 1'b1, "R2", "room flag empty depth 2", {31'h0, fifo_room2}, 32'h1);
        write_cell(32'hA0000001, 8'h00, 8'h01, 0, 0);
        chk(fifo_room2 == 1'b0, "R2", "room flag one byte depth 2", {31'h0, fifo_room2}, 32'h0);
        write_cell(32'hA0000001, 8'h00, 8'h01, 1, 52);
        write_cell(32'hA0000002, 8'h00, 8'h02, 0, 52);
        write_cell(32'hA0000003, 8'h00, 8'h03, 0, 52);
        expect_cell(1'b1, 32'hA0000001, 8'h00, 8'h01, 1'b0, "R1");
        expect_cell(1'b1, 32'hA0000002, 8'h00, 8'h02, 1'b0, "R1");
        expect_cell(1'b0, '0, '0, '0, 1'b0, "R1");

        // R2 three-cell depth
        cfg_depth_sel = 2'd1;
        write_cell(32'hB0000001, 8'h00, 8'h11, 0, 52);
        chk(fifo_room2 == 1'b1, "R2", "room flag 1 cell depth 3", {31'h0, fifo_room2}, 32'h1);
        write_cell(32'hB0000002, 8'h00, 8'h12, 0, 0);
        chk(fifo_room2 == 1'b0, "R2", "room flag 1 cell+1 depth 3", {31'h0, fifo_room2}, 32'h0);
        write_cell(32'hB0000002, 8'h00, 8'h12, 1, 52);
        expect_cell(1'b1, 32'hB0000001, 8'h00, 8'h11, 1'b0, "R1");
        expect_cell(1'b1, 32'hB0000002, 8'h00, 8'h12, 1'b0, "R1");

        // R1 R2 four-cell depth holds three cells
        cfg_depth_sel = 2'd3;
        write_cell(32'hC0000001, 8'h00, 8'h21, 0, 52);
        write_cell(32'hC0000002, 8'h00, 8'h22, 0, 52);
        chk(fifo_room2 == 1'b1, "R2", "room flag 2 cells depth 4", {31'h0, fifo_room2}, 32'h1);
        write_cell(32'hC0000003, 8'h00, 8'h23, 0, 0);
        chk(fifo_room2 == 1'b0, "R2", "room flag 2 cells+1 depth 4", {31'h0, fifo_room2}, 32'h0);
        write_cell(32'hC0000003, 8'h00, 8'h23, 1, 52);
        expect_cell(1'b1, 32'hC0000001, 8'h00, 8'h21, 1'b0, "R1");
        expect_cell(1'b1, 32'hC0000002, 8'h00, 8'h22, 1'b0, "R1");
        expect_cell(1'b1, 32'hC0000003, 8'h00, 8'h23, 1'b0, "R1");
        chk(32'(tx_cell_count) == exp_cnt, "R8", "count held at maximum", 32'(tx_cell_count), exp_cnt);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule